// File: doc/BRIEF.md
# Cached FFT Address Generator (Variable Length)

This block turns the loop counters of a radix-2 cached FFT sequencer into the addresses one butterfly needs. It produces the main-memory addresses of both butterfly operands, their addresses inside the cache and the twiddle-ROM index. The transform is split into two super stages. In each super stage the word positions that select a group stay fixed, so every group can live in the cache while its passes run. Only the largest transform (2048 points, 11 address bits) is mapped directly. A smaller transform uses the same map and then drops as many low-order digits as the size code asks for.

In super stage 0 the cache field is the upper 6 address bits and the group field is the lower 5. Super stage 0 runs 6 passes, and in pass p it processes global bit 10-p. In super stage 1 the group field is the upper 6 bits and the cache field is the lower 5. Super stage 1 runs 5 passes, and in pass p it processes global bit 4-p. A sequencer presents one counter set per cycle, qualified by a valid strobe. The addresses come out registered one cycle later.

Top module: `cfft_addr_gen`

## Requirements
- R1: When `inValid` is high at a rising edge, `outValid` is high after that edge and the outputs reflect those inputs. When `inValid` is low at the edge, `outValid` is low after it.
- R2: In super stage 0 (`superSel`=0), the full-size memory address is the cache index in bits 10:5 and `grpCnt[4:0]` in bits 4:0. `grpCnt[5]` is ignored.
- R3: In super stage 1 (`superSel`=1), the full-size memory address is `grpCnt[5:0]` in bits 10:5 and the 5-bit cache index in bits 4:0. `bflyCnt[4]` is ignored.
- R4: The cache index is the butterfly count with the operand bit inserted at position q. Bits below q stay in place and bits at q and above move up by one. q is 5-p in super stage 0 and 4-p in super stage 1. The top operand uses operand bit 0 and the bottom operand uses 1. The pass index must be below 6 in super stage 0 and below 5 in super stage 1.
- R5: The cache address output is the 6-bit cache index in super stage 0. In super stage 1 it is the 5-bit index shifted right by the drop count d and zero-extended.
- R6: Size code k from 0 to 5 selects 64·2^k points with d = 5-k. Codes 6 and 7 select 2048 points with d = 0. Both memory address outputs equal the full-size memory address shifted right by d.
- R7: The ROM index is formed from the full-size top-operand address. All bits at and above the processed global bit g are cleared, and so are its low d bits. The result is shifted left by 10-g and truncated to 10 bits.
- R8: The two memory address outputs differ only in bit g-d when g ≥ d, with the bottom one holding 1 there. They are equal when g < d.
- R9: While `rstN` is low, every output is zero.
- R10: While `inValid` is low, every address output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Counter set valid this cycle |
| superSel | input | 1 | Super stage index |
| passIdx | input | 3 | Pass within the group |
| grpCnt | input | 6 | Group counter |
| bflyCnt | input | 5 | Butterfly counter within the pass |
| sizeCode | input | 3 | Transform length selector |
| outValid | output | 1 | Registered addresses valid |
| memAddrTop | output | 11 | Memory address, top operand |
| memAddrBot | output | 11 | Memory address, bottom operand |
| cacheAddrTop | output | 6 | Cache address, top operand |
| cacheAddrBot | output | 6 | Cache address, bottom operand |
| romAddr | output | 10 | Twiddle ROM index |

## Verification
The assertions assume the sequencer never presents a pass index beyond the last pass of the selected super stage: 6 passes in stage 0 and 5 in stage 1. Operand-pairing and hold checks also rely on counters being sampled only when the valid strobe is high. The random stimulus draws the pass index modulo the selected stage's pass count and draws counters and size codes freely, including the unused counter bits and the two spare size codes. Directed cases cover the smallest and largest lengths and the pass that moves the processed bit below the discarded digits.

// File: rtl/cfag_pkg.sv
package cfag_pkg;
  localparam int MaxLog  = 11;
  localparam int MinLog  = 6;
  localparam int AddrW   = MaxLog;
  localparam int Cache0W = (MaxLog + 1) / 2;
  localparam int Cache1W = MaxLog - Cache0W;
  localparam int Grp0W   = MaxLog - Cache0W;
  localparam int GrpW    = Cache0W;
  localparam int BflyW   = Cache0W - 1;
  localparam int RomW    = MaxLog - 1;
  localparam int PassW   = $clog2(Cache0W);
  localparam int CodeW   = 3;
  localparam int PosW    = $clog2(MaxLog);
  localparam int MaxDrop = MaxLog - MinLog;
  localparam int DropW   = $clog2(MaxDrop + 1);

  typedef struct packed {
    logic             stageHi;
    logic [PosW-1:0]  cachePos;
    logic [PosW-1:0]  globPos;
    logic [PosW-1:0]  twShift;
    logic [DropW-1:0] drop;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfag_ctrl.sv
module cfag_ctrl
  import cfag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             superSel,
  input  logic [PassW-1:0] passIdx,
  input  logic [CodeW-1:0] sizeCode,
  output ctrlStrobe_t      strb
);
  logic [PosW-1:0] passExt;
  assign passExt = PosW'(passIdx);

  always_comb begin
    strb.stageHi = superSel;
    if (superSel) begin
      strb.cachePos = PosW'(Cache1W - 1) - passExt;
      strb.globPos  = PosW'(Cache1W - 1) - passExt;
    end else begin
      strb.cachePos = PosW'(Cache0W - 1) - passExt;
      strb.globPos  = PosW'(Grp0W + Cache0W - 1) - passExt;
    end
    strb.twShift = PosW'(MaxLog - 1) - strb.globPos;
    if (32'(sizeCode) > MaxDrop) strb.drop = '0;
    else strb.drop = DropW'(MaxDrop - 32'(sizeCode));
  end

  // input assumption on the pass range (R4)
  p_pass_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (superSel ? (32'(passIdx) < Cache1W) : (32'(passIdx) < Cache0W)));
endmodule

// File: rtl/cfag_dpath.sv
module cfag_dpath
  import cfag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [GrpW-1:0]  grpCnt,
  input  logic [BflyW-1:0] bflyCnt,
  input  ctrlStrobe_t      strb,
  output logic             outValid,
  output logic [AddrW-1:0] memAddrTop,
  output logic [AddrW-1:0] memAddrBot,
  output logic [Cache0W-1:0] cacheAddrTop,
  output logic [Cache0W-1:0] cacheAddrBot,
  output logic [RomW-1:0]  romAddr
);
  logic [Cache0W-1:0] bflyPad;
  logic [Cache0W-1:0] cIdx   [2];
  logic [AddrW-1:0]   memMax [2];
  logic [AddrW-1:0]   memRed [2];
  logic [Cache0W-1:0] cRed   [2];
  logic [AddrW-1:0]   twMask;
  logic [AddrW-1:0]   twFull;

  always_comb begin
    if (strb.stageHi) bflyPad = {2'b00, bflyCnt[Cache1W-2:0]};
    else bflyPad = {1'b0, bflyCnt};
  end

  for (genvar op = 0; op < 2; op++) begin : g_operand
    always_comb begin
      cIdx[op][0] = (strb.cachePos == '0) ? 1'(op) : bflyPad[0];
      for (int i = 1; i < Cache0W; i++) begin
        if (PosW'(i) < strb.cachePos) cIdx[op][i] = bflyPad[i];
        else if (PosW'(i) == strb.cachePos) cIdx[op][i] = 1'(op);
        else cIdx[op][i] = bflyPad[i-1];
      end
      if (strb.stageHi) memMax[op] = {grpCnt, cIdx[op][Cache1W-1:0]};
      else memMax[op] = {cIdx[op], grpCnt[Grp0W-1:0]};
      memRed[op] = memMax[op] >> strb.drop;
      if (strb.stageHi) cRed[op] = cIdx[op] >> strb.drop;
      else cRed[op] = cIdx[op];
    end
  end

  always_comb begin
    twMask = ((AddrW'(1) << strb.globPos) - AddrW'(1)) &
             ~((AddrW'(1) << strb.drop) - AddrW'(1));
    twFull = (memMax[0] & twMask) << strb.twShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      memAddrTop   <= '0;
      memAddrBot   <= '0;
      cacheAddrTop <= '0;
      cacheAddrBot <= '0;
      romAddr      <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        memAddrTop   <= memRed[0];
        memAddrBot   <= memRed[1];
        cacheAddrTop <= cRed[0];
        cacheAddrBot <= cRed[1];
        romAddr      <= twFull[RomW-1:0];
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_pair_one_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(memAddrTop ^ memAddrBot) <= 1 && memAddrTop <= memAddrBot));
  p_cache_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(cacheAddrTop ^ cacheAddrBot) <= 1 && cacheAddrTop <= cacheAddrBot));
  p_hold_mem_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(memAddrTop) && $stable(memAddrBot) && $stable(romAddr)));
endmodule

// File: rtl/cfft_addr_gen.sv
module cfft_addr_gen
  import cfag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             superSel,
  input  logic [PassW-1:0] passIdx,
  input  logic [GrpW-1:0]  grpCnt,
  input  logic [BflyW-1:0] bflyCnt,
  input  logic [CodeW-1:0] sizeCode,
  output logic             outValid,
  output logic [AddrW-1:0] memAddrTop,
  output logic [AddrW-1:0] memAddrBot,
  output logic [Cache0W-1:0] cacheAddrTop,
  output logic [Cache0W-1:0] cacheAddrBot,
  output logic [RomW-1:0]  romAddr
);
  ctrlStrobe_t strb;

  cfag_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .superSel(superSel),
    .passIdx(passIdx), .sizeCode(sizeCode), .strb(strb)
  );

  cfag_dpath dpath_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .grpCnt(grpCnt),
    .bflyCnt(bflyCnt), .strb(strb), .outValid(outValid),
    .memAddrTop(memAddrTop), .memAddrBot(memAddrBot),
    .cacheAddrTop(cacheAddrTop), .cacheAddrBot(cacheAddrBot),
    .romAddr(romAddr)
  );

  // smallest length keeps addresses inside 64 words (R6)
  p_small_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == '0) |=> ((memAddrTop >> MinLog) == '0 && (memAddrBot >> MinLog) == '0));
endmodule

// File: tb/cfft_addr_gen_tb_top.sv
module cfft_addr_gen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       superSel = 1'b0;
  logic [2:0] passIdx = '0;
  logic [5:0] grpCnt = '0;
  logic [4:0] bflyCnt = '0;
  logic [2:0] sizeCode = '0;
  logic       outValid;
  logic [10:0] memAddrTop, memAddrBot;
  logic [5:0]  cacheAddrTop, cacheAddrBot;
  logic [9:0]  romAddr;

  int total = 0;
  int bad = 0;
  int eMT = 0, eMB = 0, eCT = 0, eCB = 0, eR = 0, eX = 0, eCX = 0;
  int seedDummy;

  always #4 clk = ~clk;

  cfft_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .superSel(superSel),
    .passIdx(passIdx), .grpCnt(grpCnt), .bflyCnt(bflyCnt), .sizeCode(sizeCode),
    .outValid(outValid), .memAddrTop(memAddrTop), .memAddrBot(memAddrBot),
    .cacheAddrTop(cacheAddrTop), .cacheAddrBot(cacheAddrBot), .romAddr(romAddr)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference computed from the requirement text
  task automatic model(input int st, input int ps, input int gr, input int bf, input int code);
    int d, cw, q, g, bfe, cT, cB, mT, mB, mask;
    d   = (code > 5) ? 0 : 5 - code;                 // R6
    cw  = st ? 5 : 6;
    q   = cw - 1 - ps;                               // R4
    bfe = st ? (bf & 15) : (bf & 31);                // R3 ignores bit 4
    cT  = ((bfe >> q) << (q + 1)) | (bfe & ((1 << q) - 1));
    cB  = cT | (1 << q);
    if (st) begin mT = (gr << 5) | cT; mB = (gr << 5) | cB; end   // R3
    else begin mT = (cT << 5) | (gr & 31); mB = (cB << 5) | (gr & 31); end // R2
    g = st ? q : q + 5;
    eMT = mT >> d; eMB = mB >> d;
    eCT = st ? (cT >> d) : cT;                       // R5
    eCB = st ? (cB >> d) : cB;
    mask = ((1 << g) - 1) & ~((1 << d) - 1);         // R7
    eR = ((mT & mask) << (10 - g)) & 1023;
    eX = (g >= d) ? (1 << (g - d)) : 0;              // R8
    eCX = eCT ^ eCB;
  endtask

  task automatic step(input string tag, input int st, input int ps, input int gr,
                      input int bf, input int code, input bit vld);
    @(negedge clk);
    inValid = vld; superSel = st[0]; passIdx = 3'(ps); grpCnt = 6'(gr);
    bflyCnt = 5'(bf); sizeCode = 3'(code);
    if (vld) model(st, ps, gr, bf, code);
    @(posedge clk);
    @(negedge clk);
    check({"R1 ", tag}, int'(outValid), int'(vld));
    check({tag, " memTop"}, int'(memAddrTop), eMT);
    check({tag, " memBot"}, int'(memAddrBot), eMB);
    check(vld ? "R5 cacheTop" : "R10 cacheTop", int'(cacheAddrTop), eCT);
    check(vld ? "R5 cacheBot" : "R10 cacheBot", int'(cacheAddrBot), eCB);
    check(vld ? "R7 rom" : "R10 rom", int'(romAddr), eR);
    check("R8 pair", int'(memAddrTop ^ memAddrBot), eX);
    check("R4 cache pair", int'(cacheAddrTop ^ cacheAddrBot), eCX);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'h5eed_c0de);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset valid", int'(outValid), 0);
    check("R9 reset memTop", int'(memAddrTop), 0);
    check("R9 reset memBot", int'(memAddrBot), 0);
    check("R9 reset rom", int'(romAddr), 0);
    check("R9 reset cache", int'(cacheAddrBot), 0);
    rstN = 1'b1;

    // directed corners
    step("R10 hold after reset", 0, 0, 5, 5, 5, 1'b0);
    step("R2 full stage0 pass0", 0, 0, 0, 0, 5, 1'b1);
    step("R2 grp bit5 ignored", 0, 2, 63, 21, 5, 1'b1);
    step("R3 bfly bit4 ignored", 1, 1, 42, 31, 5, 1'b1);
    step("R3 last pass", 1, 4, 17, 9, 6, 1'b1);
    step("R6 64pt stage0", 0, 0, 31, 31, 0, 1'b1);
    step("R6 64pt stage1", 1, 0, 63, 15, 0, 1'b1);
    step("R6 code7", 0, 3, 12, 19, 7, 1'b1);
    step("R6 code5", 0, 3, 12, 19, 5, 1'b1);
    step("R8 bit discarded", 1, 4, 9, 3, 2, 1'b1);
    step("R7 last stage0 pass", 0, 5, 30, 27, 4, 1'b1);
    step("R10 hold", 1, 2, 1, 2, 3, 1'b0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int st, ps;
      st = int'($urandom % 2);
      ps = int'($urandom % (st ? 5 : 6));
      step(st ? "R3 random" : "R2 random", st, ps, int'($urandom % 64),
           int'($urandom % 32), int'($urandom % 8), ($urandom % 4) != 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule